// File: doc/BRIEF.md
# Two-Bank Interleaved Frame-Buffer Write Controller

This block accepts word-addressed write requests over a valid/ready handshake and turns each one into a write on a frame buffer built from two memory banks. The banks share one address bus and one data bus. Each bank has its own column strobe, write enable and output enable. The least significant bit of the word address picks the bank, and the remaining bits form the address sent to the memories.

A write holds the bus for one cycle. While that write is on the bus, the controller looks at the next request. If that request is for the word right after the current one, it is accepted in the same cycle and goes out on the following cycle, so it lands in the other bank. This lets one bank recover while the other is written. In all other cases the current write is stretched by one finish cycle, and the controller then spends one idle cycle before it accepts new work. Sequential streams therefore run at one word per cycle. Every break in the sequence costs two cycles.

Top module: `ilv_wr_ctrl`

## Requirements
- R1: For a write of word address A, the column strobe and write enable of bank A[0] are driven low, and those of the other bank stay high (bank 0 holds even words, bank 1 holds odd words).
- R2: During a write cycle and during its finish cycle, the memory address equals A shifted right by one bit and the memory data equals the data of the request.
- R3: A request accepted at a clock edge (valid and ready both high) drives its bank strobes in the cycle that follows that edge.
- R4: While a write to A is on the bus, ready is high exactly when the presented address equals A+1. Such a request is accepted and written in the next cycle, with no cycle inserted between the two writes.
- R5: If no sequential request is accepted during a write cycle, the next cycle is a finish cycle. In it the same bank strobes stay low, address and data are held, and ready is low.
- R6: The cycle after a finish cycle is idle: all strobes are high and ready is high.
- R7: In an idle cycle ready is high for any address, so the first write after idle is accepted regardless of any earlier address.
- R8: Both output enables stay high (inactive) at all times.
- R9: Sequence detection does not wrap. A request for address 0 that follows a write to the highest address is non-sequential.
- R10: During and right after reset, all strobes are high and ready is high.
- R11: At no time is more than one bank's column strobe low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Write request present |
| req_ready | output | 1 | Request accepted when high together with req_valid |
| req_addr | input | AW | Word address of the request |
| req_data | input | DW | Write data of the request |
| mem_addr | output | AW-1 | Shared address bus to both banks |
| mem_data | output | DW | Shared data bus to both banks |
| mem_cas_n | output | 2 | Column strobe per bank, active low |
| mem_we_n | output | 2 | Write enable per bank, active low |
| mem_oe_n | output | 2 | Output enable per bank, active low, held inactive |

## Verification
The assertions assume that the requester follows valid/ready rules: a request is counted only on an edge where both are high, and its address is stable and known while valid is high. The bench drives inputs only between clock edges and holds a request until it sees ready. It sweeps every ordered pair of addresses in a 16-word configuration, including the pair that would wrap from the top address to zero. It also runs sequential bursts of lengths one to four from every start address that fits without wrapping.

// File: rtl/ilv_wr_pkg.sv
package ilv_wr_pkg;

    // Number of interleaved banks; the bank index is the low address bits.
    localparam int NBANK = 2;
    localparam int BSW   = $clog2(NBANK);

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_WRITE  = 2'd1,
        ST_FINISH = 2'd2
    } wr_state_e;

endpackage

// File: rtl/ilv_seq_detect.sv
// Decides whether a new address continues the current one by exactly one word.
// The comparison is one bit wider than the address, so the top address
// followed by zero never counts as a continuation.
module ilv_seq_detect #(
    parameter int AW = 16
) (
    input  logic [AW-1:0] cur_addr,
    input  logic [AW-1:0] nxt_addr,
    output logic          is_next
);
    localparam int EW = AW + 1;

    logic [EW-1:0] succ_ext;
    logic [EW-1:0] nxt_ext;

    always_comb begin
        succ_ext = {1'b0, cur_addr} + EW'(1);
        nxt_ext  = {1'b0, nxt_addr};
        is_next  = (succ_ext == nxt_ext);
    end
endmodule

// File: rtl/ilv_bank_steer.sv
// Turns the registered bank index and activity flag into per-bank strobes.
module ilv_bank_steer
    import ilv_wr_pkg::*;
#(
    parameter int NB = NBANK,
    parameter int SW = BSW
) (
    input  logic          active,
    input  logic [SW-1:0] bank_sel,
    output logic [NB-1:0] cas_n,
    output logic [NB-1:0] we_n,
    output logic [NB-1:0] oe_n
);
    for (genvar b = 0; b < NB; b++) begin : g_bank
        logic hit;
        always_comb begin
            hit      = active && (bank_sel == SW'(b));
            cas_n[b] = ~hit;
            we_n[b]  = ~hit;
            oe_n[b]  = 1'b1;
        end
    end
endmodule

// File: rtl/ilv_wr_ctrl.sv
module ilv_wr_ctrl
    import ilv_wr_pkg::*;
#(
    parameter int AW = 16,
    parameter int DW = 32
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 req_valid,
    output logic                 req_ready,
    input  logic [AW-1:0]        req_addr,
    input  logic [DW-1:0]        req_data,
    output logic [AW-BSW-1:0]    mem_addr,
    output logic [DW-1:0]        mem_data,
    output logic [NBANK-1:0]     mem_cas_n,
    output logic [NBANK-1:0]     mem_we_n,
    output logic [NBANK-1:0]     mem_oe_n
);
    localparam int MAW = AW - BSW;

    typedef struct packed {
        wr_state_e       state;
        logic [AW-1:0]   addr;
        logic [DW-1:0]   data;
    } ctrl_regs_t;

    ctrl_regs_t regs_d, regs_q;
    logic       seq_hit;
    logic       accept;

    ilv_seq_detect #(.AW(AW)) u_seq (
        .cur_addr (regs_q.addr),
        .nxt_addr (req_addr),
        .is_next  (seq_hit)
    );

    always_comb begin
        regs_d = regs_q;
        unique case (regs_q.state)
            ST_IDLE:   req_ready = 1'b1;
            ST_WRITE:  req_ready = seq_hit;
            default:   req_ready = 1'b0;
        endcase
        accept = req_valid && req_ready;

        unique case (regs_q.state)
            ST_IDLE, ST_WRITE: begin
                if (accept) begin
                    regs_d.state = ST_WRITE;
                    regs_d.addr  = req_addr;
                    regs_d.data  = req_data;
                end else if (regs_q.state == ST_WRITE) begin
                    regs_d.state = ST_FINISH;
                end
            end
            default: regs_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            regs_q <= '{state: ST_IDLE, addr: '0, data: '0};
        end else begin
            regs_q <= regs_d;
        end
    end

    ilv_bank_steer #(.NB(NBANK), .SW(BSW)) u_steer (
        .active   (regs_q.state != ST_IDLE),
        .bank_sel (regs_q.addr[BSW-1:0]),
        .cas_n    (mem_cas_n),
        .we_n     (mem_we_n),
        .oe_n     (mem_oe_n)
    );

    assign mem_addr = regs_q.addr[AW-1:BSW];
    assign mem_data = regs_q.data;

    logic [MAW-1:0] unused_chk;
    assign unused_chk = mem_addr;
endmodule

// File: rtl/ilv_wr_checker.sv
module ilv_wr_checker #(
    parameter int AW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic          req_valid,
    input logic          req_ready,
    input logic [AW-1:0] req_addr,
    input logic [AW-2:0] mem_addr,
    input logic [1:0]    mem_cas_n,
    input logic [1:0]    mem_we_n,
    input logic [1:0]    mem_oe_n
);
    logic acc;
    assign acc = req_valid && req_ready;

    assert_one_bank_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(~mem_cas_n) <= 1);

    assert_oe_inactive_R8: assert property (@(posedge clk) disable iff (!rst_n)
        mem_oe_n == 2'b11);

    assert_we_tracks_cas_R1: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we_n == mem_cas_n);

    assert_bank_pick_R1: assert property (@(posedge clk) disable iff (!rst_n)
        acc |=> (mem_cas_n == ($past(req_addr[0]) ? 2'b01 : 2'b10)));

    assert_addr_shift_R2: assert property (@(posedge clk) disable iff (!rst_n)
        acc |=> (mem_addr == $past(req_addr[AW-1:1])));

    assert_finish_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        acc ##1 !acc |=> ($stable(mem_cas_n) && $stable(mem_addr) && !req_ready));
endmodule

bind ilv_wr_ctrl ilv_wr_checker #(.AW(AW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .req_addr  (req_addr),
    .mem_addr  (mem_addr),
    .mem_cas_n (mem_cas_n),
    .mem_we_n  (mem_we_n),
    .mem_oe_n  (mem_oe_n)
);

// File: tb/sim_ilv_wr_ctrl.sv
module sim_ilv_wr_ctrl;
    localparam int AW = 4;
    localparam int DW = 32;
    localparam int TOP = (1 << AW) - 1;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic          req_ready;
    logic [AW-1:0] req_addr = '0;
    logic [DW-1:0] req_data = '0;
    logic [AW-2:0] mem_addr;
    logic [DW-1:0] mem_data;
    logic [1:0]    mem_cas_n, mem_we_n, mem_oe_n;

    int n_tests = 0;
    int n_fail  = 0;

    always #10 clk = ~clk;

    ilv_wr_ctrl #(.AW(AW), .DW(DW)) u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_addr(req_addr), .req_data(req_data), .mem_addr(mem_addr),
        .mem_data(mem_data), .mem_cas_n(mem_cas_n), .mem_we_n(mem_we_n),
        .mem_oe_n(mem_oe_n)
    );

    task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    function automatic logic [DW-1:0] pat(int a, int k);
        return 32'hC0DE_0000 + 32'(a * 64 + k);
    endfunction

    function automatic logic [1:0] strobe_of(int a);
        return (a % 2 == 1) ? 2'b01 : 2'b10;
    endfunction

    task automatic exp_write(int a, logic [DW-1:0] d, string req);
        chk({req, " cas"}, 64'(mem_cas_n), 64'(strobe_of(a)));
        chk("R1 we", 64'(mem_we_n), 64'(strobe_of(a)));
        chk("R2 addr", 64'(mem_addr), 64'(a / 2));
        chk("R2 data", 64'(mem_data), 64'(d));
        chk("R8 oe", 64'(mem_oe_n), 64'h3);
    endtask

    task automatic exp_finish(int a, logic [DW-1:0] d);
        chk("R5 cas", 64'(mem_cas_n), 64'(strobe_of(a)));
        chk("R5 addr", 64'(mem_addr), 64'(a / 2));
        chk("R5 data", 64'(mem_data), 64'(d));
        chk("R5 ready", 64'(req_ready), 64'h0);
    endtask

    task automatic exp_idle(string req);
        chk({req, " cas"}, 64'(mem_cas_n), 64'h3);
        chk({req, " we"}, 64'(mem_we_n), 64'h3);
        chk({req, " ready"}, 64'(req_ready), 64'h1);
    endtask

    task automatic do_pair(int a, int b);
        logic [DW-1:0] da, db;
        bit seq;
        da = pat(a, 1);
        db = pat(b, 2);
        req_valid = 1'b1; req_addr = AW'(a); req_data = da;
        #1 chk("R7 ready in idle", 64'(req_ready), 64'h1);
        step();
        exp_write(a, da, "R3");
        req_addr = AW'(b); req_data = db;
        #1;
        seq = (b == a + 1);
        if (a == TOP && b == 0) chk("R9 no wrap", 64'(req_ready), 64'h0);
        else chk("R4 ready on sequence", 64'(req_ready), 64'(seq));
        if (seq) begin
            step();
            exp_write(b, db, "R4");
            req_valid = 1'b0;
            step(); exp_finish(b, db);
            step(); exp_idle("R6");
        end else begin
            step(); exp_finish(a, da);
            step(); exp_idle("R6");
            step(); exp_write(b, db, "R7");
            req_valid = 1'b0;
            step(); exp_finish(b, db);
            step(); exp_idle("R6");
        end
    endtask

    task automatic do_burst(int s, int len);
        for (int k = 0; k < len; k++) begin
            req_valid = 1'b1; req_addr = AW'(s + k); req_data = pat(s + k, 3 + k);
            step();
            exp_write(s + k, pat(s + k, 3 + k), "R4 burst");
        end
        req_valid = 1'b0;
        step(); exp_finish(s + len - 1, pat(s + len - 1, 2 + len));
        step(); exp_idle("R6");
    endtask

    task automatic finish_up();
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual hung expected done");
        finish_up();
    end

    initial begin
        repeat (3) step();
        exp_idle("R10 in reset");
        chk("R8 oe in reset", 64'(mem_oe_n), 64'h3);
        rst_n = 1'b1;
        step();
        exp_idle("R10 after reset");
        for (int a = 0; a <= TOP; a++)
            for (int b = 0; b <= TOP; b++)
                do_pair(a, b);
        for (int s = 0; s <= TOP; s++)
            for (int len = 1; len <= 4; len++)
                if (s + len - 1 <= TOP) do_burst(s, len);
        for (int i = 0; i < 4; i++) begin
            step();
            exp_idle("R6 quiet");
            chk("R11 strobes", 64'($countones(~mem_cas_n)), 64'h0);
        end
        finish_up();
    end
endmodule